// File: doc/BRIEF.md
# GPIO Alternate-Function Commit Guard

This block holds the per-pin configuration registers of a small GPIO port, some of whose pins double as debug-port pins. For every pin it keeps a digital-enable bit, a pull-up enable bit and an alternate-function select bit, and drives them out as three configuration vectors. The pins named in the `PROT_MASK` parameter come out of reset with all three bits set, so the debug port works before software runs.

The alternate-function select bits of protected pins are guarded twice. A key register must first be opened by writing a 32-bit key. A per-pin commit register, which can itself only be written while the key register is open, then picks which protected bits a later alternate-function write may change. Unprotected pins and the enable and pull-up bits are never guarded.

Software reaches the block over a simple synchronous bus: a word address, 32-bit write data, a write strobe, and a registered read data output that returns the addressed register one cycle after the address is presented.

Top module: `gcg_port_guard`

## Requirements
- R1: After reset, for every pin in `PROT_MASK` the enable, pull-up and alternate-select outputs are 1, and for every other pin they are 0. The key register reads 1 and the commit register reads 0.
- R2: A write of 0x1ACCE551 to address 3 (key register) opens the guard, and it then reads 0. A write of any other value to address 3 closes it, and it then reads 1.
- R3: While the guard is closed, writes to address 4 (commit register) leave it unchanged.
- R4: While the guard is closed, a write to address 0 (alternate-select register) leaves every protected bit unchanged, whatever the commit register holds.
- R5: While the guard is open, a write to address 0 leaves unchanged every protected bit whose commit bit is 0.
- R6: A write to address 0 always loads the bits of unprotected pins from write data bits [NPINS-1:0].
- R7: While the guard is open, a write to address 0 with some protected commit bits set changes exactly those protected bits and leaves the other protected bits unchanged.
- R8: Writes to address 1 (digital enable) and address 2 (pull-up) load bits [NPINS-1:0] directly, with no guard.
- R9: Read data is registered. It shows the register selected by the address one cycle earlier, zero-extended to 32 bits. Addresses 5 to 7 read 0.
- R10: An allowed write of 0 to a committed protected bit drives that pin's alternate-select output to 0, which is plain GPIO.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| we | input | 1 | Write strobe |
| rdata | output | 32 | Registered read data |
| pin_den | output | NPINS | Digital enable per pin |
| pin_pull_up | output | NPINS | Pull-up enable per pin |
| pin_alt_sel | output | NPINS | Alternate-function select per pin |

## Verification
The assertions assume that `addr`, `wdata` and `we` are known and stable around every rising edge, that reset is held from time zero for at least one edge, and that only one register is written per cycle. The stimulus meets these by changing bus inputs only on falling edges and by giving each write and each read its own cycle. It walks through each guard state: closed, open with no commits, open with partial commits, and closed again after commits were made.

// File: rtl/gcg_pkg.sv
package gcg_pkg;

    localparam int          REG_AW     = 3;
    localparam int          BUS_W      = 32;
    localparam logic [31:0] UNLOCK_KEY = 32'h1ACCE551;

    typedef enum logic [REG_AW-1:0] {
        SEL_ALT    = 3'd0,
        SEL_DEN    = 3'd1,
        SEL_PULL   = 3'd2,
        SEL_KEY    = 3'd3,
        SEL_COMMIT = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic alt;
        logic den;
        logic pull;
        logic key;
        logic commit;
    } wr_dec_t;

    function automatic wr_dec_t decode_write(input logic we, input logic [REG_AW-1:0] a);
        wr_dec_t d;
        d.alt    = we && (a == SEL_ALT);
        d.den    = we && (a == SEL_DEN);
        d.pull   = we && (a == SEL_PULL);
        d.key    = we && (a == SEL_KEY);
        d.commit = we && (a == SEL_COMMIT);
        return d;
    endfunction

    // Next value of one protected select bit under the two-stage guard.
    function automatic logic guarded_next(input logic cur, input logic nxt,
                                          input logic open, input logic cmt);
        return (open && cmt) ? nxt : cur;
    endfunction

endpackage

// File: rtl/gcg_key_lock.sv
module gcg_key_lock
    import gcg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [BUS_W-1:0] wdata,
    output logic             open
);
    always_ff @(posedge clk) begin
        if (rst)        open <= 1'b0;
        else if (wr_en) open <= (wdata == UNLOCK_KEY);
    end
endmodule

// File: rtl/gcg_plain_reg.sv
module gcg_plain_reg #(
    parameter int             W       = 8,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)        q <= RST_VAL;
        else if (wr_en) q <= d;
    end
endmodule

// File: rtl/gcg_alt_bank.sv
module gcg_alt_bank
    import gcg_pkg::*;
#(
    parameter int               NPINS     = 8,
    parameter logic [NPINS-1:0] PROT_MASK = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [NPINS-1:0] d,
    input  logic             open,
    input  logic [NPINS-1:0] commit,
    output logic [NPINS-1:0] q
);
    for (genvar i = 0; i < NPINS; i++) begin : g_bit
        if (PROT_MASK[i]) begin : g_guarded
            always_ff @(posedge clk) begin
                if (rst)        q[i] <= 1'b1;
                else if (wr_en) q[i] <= guarded_next(q[i], d[i], open, commit[i]);
            end
        end else begin : g_free
            always_ff @(posedge clk) begin
                if (rst)        q[i] <= 1'b0;
                else if (wr_en) q[i] <= d[i];
            end
        end
    end
endmodule

// File: rtl/gcg_port_guard.sv
module gcg_port_guard
    import gcg_pkg::*;
#(
    parameter int               NPINS     = 8,
    parameter logic [NPINS-1:0] PROT_MASK = 8'h1F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic              we,
    output logic [BUS_W-1:0]  rdata,
    output logic [NPINS-1:0]  pin_den,
    output logic [NPINS-1:0]  pin_pull_up,
    output logic [NPINS-1:0]  pin_alt_sel
);
    localparam int PAD = BUS_W - NPINS;

    wr_dec_t          dec;
    logic             port_open;
    logic [NPINS-1:0] commit_q;
    logic [BUS_W-1:0] rd_next;

    assign dec = decode_write(we, addr);

    gcg_key_lock u_lock (
        .clk(clk), .rst(rst), .wr_en(dec.key), .wdata(wdata), .open(port_open)
    );

    gcg_plain_reg #(.W(NPINS), .RST_VAL('0)) u_commit (
        .clk(clk), .rst(rst), .wr_en(dec.commit && port_open),
        .d(wdata[NPINS-1:0]), .q(commit_q)
    );

    gcg_plain_reg #(.W(NPINS), .RST_VAL(PROT_MASK)) u_den (
        .clk(clk), .rst(rst), .wr_en(dec.den), .d(wdata[NPINS-1:0]), .q(pin_den)
    );

    gcg_plain_reg #(.W(NPINS), .RST_VAL(PROT_MASK)) u_pull (
        .clk(clk), .rst(rst), .wr_en(dec.pull), .d(wdata[NPINS-1:0]), .q(pin_pull_up)
    );

    gcg_alt_bank #(.NPINS(NPINS), .PROT_MASK(PROT_MASK)) u_alt (
        .clk(clk), .rst(rst), .wr_en(dec.alt), .d(wdata[NPINS-1:0]),
        .open(port_open), .commit(commit_q), .q(pin_alt_sel)
    );

    always_comb begin
        case (addr)
            SEL_ALT:    rd_next = {{PAD{1'b0}}, pin_alt_sel};
            SEL_DEN:    rd_next = {{PAD{1'b0}}, pin_den};
            SEL_PULL:   rd_next = {{PAD{1'b0}}, pin_pull_up};
            SEL_KEY:    rd_next = {{(BUS_W-1){1'b0}}, ~port_open};
            SEL_COMMIT: rd_next = {{PAD{1'b0}}, commit_q};
            default:    rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= rd_next;
    end
endmodule

// File: rtl/gcg_port_guard_chk.sv
module gcg_port_guard_chk
    import gcg_pkg::*;
#(
    parameter int               NPINS     = 8,
    parameter logic [NPINS-1:0] PROT_MASK = 8'h1F
) (
    input logic              clk,
    input logic              rst,
    input logic [REG_AW-1:0] addr,
    input logic [BUS_W-1:0]  wdata,
    input logic              we,
    input logic [NPINS-1:0]  pin_den,
    input logic [NPINS-1:0]  pin_alt_sel,
    input logic              open,
    input logic [NPINS-1:0]  commit
);
    assert_key_opens_R2: assert property (@(posedge clk) disable iff (rst)
        (we && addr == SEL_KEY && wdata == UNLOCK_KEY) |=> open);

    assert_other_closes_R2: assert property (@(posedge clk) disable iff (rst)
        (we && addr == SEL_KEY && wdata != UNLOCK_KEY) |=> !open);

    assert_commit_frozen_R3: assert property (@(posedge clk) disable iff (rst)
        !open |=> $stable(commit));

    assert_prot_held_closed_R4: assert property (@(posedge clk) disable iff (rst)
        !open |=> $stable(pin_alt_sel & PROT_MASK));

    assert_uncommitted_held_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((pin_alt_sel ^ $past(pin_alt_sel)) & PROT_MASK & ~$past(commit)) == '0));

    assert_free_bits_load_R6: assert property (@(posedge clk) disable iff (rst)
        (we && addr == SEL_ALT) |=>
            ((pin_alt_sel & ~PROT_MASK) == ($past(wdata[NPINS-1:0]) & ~PROT_MASK)));

    assert_den_load_R8: assert property (@(posedge clk) disable iff (rst)
        (we && addr == SEL_DEN) |=> (pin_den == $past(wdata[NPINS-1:0])));
endmodule

bind gcg_port_guard gcg_port_guard_chk #(.NPINS(NPINS), .PROT_MASK(PROT_MASK)) u_chk (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .we(we),
    .pin_den(pin_den), .pin_alt_sel(pin_alt_sel),
    .open(port_open), .commit(commit_q)
);

// File: tb/gcg_port_guard_test.sv
`timescale 1ns/1ps
module gcg_port_guard_test;
    localparam int          NP  = 8;
    localparam logic [7:0]  PM  = 8'h1F;
    localparam logic [31:0] KEY = 32'h1ACCE551;

    typedef struct {
        logic [31:0] exp;
        string       req;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0;
    logic        rd_v = 1'b0;
    logic [31:0] rdata;
    logic [7:0]  pin_den, pin_pull_up, pin_alt_sel;

    int checks = 0;
    int failures = 0;
    sb_item_t sbq[$];

    always #4 clk = ~clk;

    gcg_port_guard #(.NPINS(NP), .PROT_MASK(PM)) uut (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .we(we),
        .rdata(rdata), .pin_den(pin_den), .pin_pull_up(pin_pull_up),
        .pin_alt_sel(pin_alt_sel)
    );

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] e, input string req);
        sb_item_t it;
        @(negedge clk);
        addr = a; we = 1'b0; rd_v = 1'b1;
        it.exp = e; it.req = req;
        sbq.push_back(it);
        @(negedge clk);
        rd_v = 1'b0;
    endtask

    task automatic chk8(input logic [7:0] act, input logic [7:0] e, input string req);
        checks++;
        if (act !== e) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, e);
        end
    endtask

    // Monitor: pops the expected item for the read launched before this edge.
    always @(posedge clk) begin
        if (rd_v) begin
            #2;
            if (sbq.size() > 0) begin
                sb_item_t it;
                it = sbq.pop_front();
                checks++;
                if (rdata !== it.exp) begin
                    failures++;
                    $display("FAIL %s actual=%h expected=%h", it.req, rdata, it.exp);
                end
            end
        end
    end

    initial begin
        #100000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset values
        chk8(pin_alt_sel, PM, "R1 alt");
        chk8(pin_den, PM, "R1 den");
        chk8(pin_pull_up, PM, "R1 pull");
        rd(3'd3, 32'd1, "R1 key reads locked");
        rd(3'd4, 32'd0, "R1 commit");
        rd(3'd0, 32'h1F, "R9 alt read");

        // R3 commit ignored while closed
        wr(3'd4, 32'hFF);
        rd(3'd4, 32'd0, "R3 commit locked");

        // R4 / R6 closed guard
        wr(3'd0, 32'h00);
        chk8(pin_alt_sel, 8'h1F, "R4 prot held");
        wr(3'd0, 32'hE0);
        chk8(pin_alt_sel, 8'hFF, "R6 free bits set");
        wr(3'd0, 32'h1F);
        chk8(pin_alt_sel, 8'h1F, "R6 free bits cleared");

        // R2 key handling
        wr(3'd3, 32'h12345678);
        rd(3'd3, 32'd1, "R2 wrong key");
        wr(3'd3, KEY);
        rd(3'd3, 32'd0, "R2 key opens");

        // R5 open but nothing committed
        wr(3'd0, 32'h00);
        chk8(pin_alt_sel, 8'h1F, "R5 uncommitted held");

        // R7 / R10 partial commit
        wr(3'd4, 32'h05);
        rd(3'd4, 32'h05, "R7 commit stored");
        wr(3'd0, 32'h00);
        chk8(pin_alt_sel, 8'h1A, "R7 partial clear");
        wr(3'd0, 32'hFF);
        chk8(pin_alt_sel, 8'hFF, "R7 partial set");
        wr(3'd0, 32'h00);
        chk8(pin_alt_sel, 8'h1A, "R10 to gpio");

        // R4 closed again with commits present
        wr(3'd4, 32'h1F);
        wr(3'd3, 32'h0);
        rd(3'd3, 32'd1, "R2 relock");
        wr(3'd0, 32'h00);
        chk8(pin_alt_sel, 8'h1A, "R4 held after relock");
        wr(3'd0, 32'hFF);
        chk8(pin_alt_sel, 8'hFA, "R6 free while locked");
        wr(3'd4, 32'h00);
        rd(3'd4, 32'h1F, "R3 commit kept");

        // R8 unguarded registers
        wr(3'd1, 32'hA5);
        chk8(pin_den, 8'hA5, "R8 den");
        rd(3'd1, 32'hA5, "R8 den read");
        wr(3'd2, 32'h3C);
        chk8(pin_pull_up, 8'h3C, "R8 pull");
        rd(3'd2, 32'h3C, "R8 pull read");

        // R9 unmapped and mapped reads
        rd(3'd7, 32'd0, "R9 unmapped");
        rd(3'd5, 32'd0, "R9 unmapped 5");
        rd(3'd0, 32'hFA, "R9 alt read");

        // R10 full commit, all protected to GPIO
        wr(3'd3, KEY);
        wr(3'd0, 32'h00);
        chk8(pin_alt_sel, 8'h00, "R10 all gpio");

        repeat (3) @(negedge clk);
        if (sbq.size() != 0) begin
            checks++; failures++;
            $display("FAIL scoreboard actual=%0d expected=0", sbq.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule